// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA

This block moves outgoing frames from memory onto a byte stream. Software places a ring of descriptors in memory. Each descriptor is three 32-bit words at consecutive word addresses. Word 0 carries the control flags: bit 31 marks the descriptor as owned by the engine, bit 30 marks the last descriptor of the ring, and bits 29:28 set to 11 mean the buffer holds a whole frame. Word 1 carries the frame length in bytes in bits 31:16. Word 2 carries the buffer byte address.

Software loads the ring base, then pulses the start input. The engine reads each owned descriptor and reads the buffer one 32-bit word at a time. It sends the bytes, least significant byte first, and then writes word 0 back with the ownership bit cleared. It then moves on to the next descriptor, or back to the ring base after a descriptor flagged as last. The engine stops by itself when it meets a descriptor it does not own.

Memory access uses a request/acknowledge port. The byte stream uses valid/ready. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the engine holds `tx_valid`, `tx_data` and `tx_last` steady and does not move on. `tx_ready` may change freely.

Top module: `txring_dma`

## Requirements
- R1: After reset, `xmit_busy`, `mem_req` and `tx_valid` are low. Whenever `xmit_busy` is low, `mem_req` and `tx_valid` stay low.
- R2: A one-cycle `xmit_go` while idle starts the engine. Writing `ring_base_wdata` with `ring_base_we` while idle sets the ring base and also moves the fetch pointer to it. The first reads of a descriptor are at pointer, pointer+4 and pointer+8, in that order.
- R3: A fetched word 0 with bit 31 clear ends the run: `xmit_busy` drops, and that descriptor is not written. `xmit_busy` stays high from start until then.
- R4: The frame is the number of bytes in word 1 bits 31:16. The bytes are sent least significant byte first from successive buffer words, and bytes beyond the length in the final word are dropped. `tx_last` is high on the final byte only.
- R5: Buffer address bits 1:0 are ignored, so reads start at the 4-byte-aligned address below it.
- R6: After the final byte is accepted, word 0 is written back with bit 31 cleared and all other bits unchanged, including the last-in-ring bit 30.
- R7: After a descriptor is written back, the next fetch is 12 bytes further on. If that descriptor had bit 30 set, the next fetch is at the ring base instead.
- R8: While `tx_ready` is low and `tx_valid` is high, `tx_valid`, `tx_data` and `tx_last` hold. No byte is lost or repeated under any pattern of back-pressure.
- R9: A descriptor with length 0 sends no bytes and is still written back.
- R10: `xmit_go` and ring base writes are ignored while `xmit_busy` is high.
- R11: A `soft_rst` pulse returns the engine to idle on the next edge. It drops `tx_valid`, writes nothing back, and resets the fetch pointer to the ring base.
- R12: Once raised, `mem_req` with its address, direction and write data holds until the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_rst | input | 1 | Software reset pulse: idle, pointer to ring base |
| ring_base_we | input | 1 | Load ring base (honoured only while idle) |
| ring_base_wdata | input | ADDR_W | New ring base byte address |
| xmit_go | input | 1 | Transmit request pulse |
| xmit_busy | output | 1 | Transmit request readback: high while running |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
A corrupt fetch pointer shows up at the ports during the next run. The first read address after start is the wrong one, or a descriptor past the last-in-ring flag is fetched. A shifter or byte counter that slips shows up within the frame as a wrong byte value, or as `tx_last` on the wrong byte or missing. A wrong write-back shows up as memory contents that differ once the engine stops. The bench checks those contents after each run, together with the read address log, so a fault in any of these places is reported within one descriptor of where it starts.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;
  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_W0, S_W1, S_W2, S_BUF, S_SEND, S_WB
  } txr_state_t;
endpackage

// File: rtl/txring_ptr.sv
module txring_ptr #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      ptr_o  <= '0;
    end else if (sw_reset) begin
      ptr_o <= base_o;
    end else if (load) begin
      base_o <= base_in;
      ptr_o  <= base_in;
    end else if (adv) begin
      ptr_o <= wrap ? base_o : ptr_o + STEP_A;
    end
  end
endmodule

// File: rtl/txring_unpack.sv
module txring_unpack #(
  parameter int WORD_W = 32,
  localparam int NB    = WORD_W / 8,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              final_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done
);
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              fin;
  logic              fire;

  assign out_valid = (cnt != '0);
  assign out_data  = sh[7:0];
  assign out_last  = fin && (cnt == CNT_W'(1));
  assign fire      = out_valid && out_ready;
  assign done      = fire && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      fin <= 1'b0;
    end else if (flush) begin
      cnt <= '0;
      fin <= 1'b0;
    end else if (load) begin
      sh  <= word_in;
      cnt <= nbytes;
      fin <= final_in;
    end else if (fire) begin
      sh  <= sh >> 8;
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NB));
  p_load_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ring_base_we,
  input  logic [ADDR_W-1:0] ring_base_wdata,
  input  logic              xmit_go,
  output logic              xmit_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  localparam int NB         = WORD_W / 8;
  localparam int CNT_W      = $clog2(NB + 1);
  localparam int DESC_BYTES = 3 * NB;
  localparam logic [ADDR_W-1:0] OFF1 = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] OFF2 = ADDR_W'(2 * NB);
  localparam logic [LEN_W-1:0]  NB_L = LEN_W'(NB);

  txr_state_t        state;
  logic [WORD_W-1:0] w0;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] bufp;
  logic [ADDR_W-1:0] base, ptr;
  logic              idle, adv, ld_buf, un_done;
  logic [CNT_W-1:0]  take;
  logic              take_final;

  assign idle       = (state == S_IDLE);
  assign xmit_busy  = !idle;
  assign adv        = (state == S_WB) && mem_ack;
  assign ld_buf     = (state == S_BUF) && mem_ack;
  assign take_final = (remain <= NB_L);
  assign take       = take_final ? remain[CNT_W-1:0] : CNT_W'(NB);

  txring_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sw_reset(soft_rst),
    .load(ring_base_we && idle), .base_in(ring_base_wdata),
    .adv(adv), .wrap(w0[LAST_BIT]), .base_o(base), .ptr_o(ptr)
  );

  txring_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst), .load(ld_buf),
    .word_in(mem_rdata), .nbytes(take), .final_in(take_final),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data),
    .out_last(tx_last), .done(un_done)
  );

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = ptr;
    case (state)
      S_W0:  mem_req = 1'b1;
      S_W1:  begin mem_req = 1'b1; mem_addr = ptr + OFF1; end
      S_W2:  begin mem_req = 1'b1; mem_addr = ptr + OFF2; end
      S_BUF: begin mem_req = 1'b1; mem_addr = bufp; end
      S_WB:  begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    mem_wdata          = w0;
    mem_wdata[OWN_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      w0     <= '0;
      remain <= '0;
      bufp   <= '0;
    end else if (soft_rst) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (xmit_go) state <= S_W0;
        S_W0: if (mem_ack) begin
          w0    <= mem_rdata;
          state <= mem_rdata[OWN_BIT] ? S_W1 : S_IDLE;
        end
        S_W1: if (mem_ack) begin
          remain <= mem_rdata[LEN_LSB +: LEN_W];
          state  <= S_W2;
        end
        S_W2: if (mem_ack) begin
          bufp  <= {mem_rdata[ADDR_W-1:2], 2'b00};
          state <= (remain == '0) ? S_WB : S_BUF;
        end
        S_BUF: if (mem_ack) begin
          bufp   <= bufp + OFF1;
          remain <= remain - LEN_W'(take);
          state  <= S_SEND;
        end
        S_SEND: if (un_done) state <= (remain == '0) ? S_WB : S_BUF;
        S_WB: if (mem_ack) state <= S_W0;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_busy |-> (!mem_req && !tx_valid));
  p_stop_unowned_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == S_W0 && mem_ack && !mem_rdata[OWN_BIT]) |=> !xmit_busy);
  p_buf_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));
  p_wb_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

// File: tb/txring_dma_test.sv
module txring_dma_test;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LST  = 32'h4000_0000;
  localparam logic [31:0] WHOL = 32'h3000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, soft_rst = 1'b0, ring_base_we = 1'b0, xmit_go = 1'b0;
  logic [15:0] ring_base_wdata = '0;
  logic        xmit_busy, mem_req, mem_we, tx_valid, tx_last;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  txring_dma #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ring_base_we(ring_base_we),
    .ring_base_wdata(ring_base_wdata), .xmit_go(xmit_go), .xmit_busy(xmit_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  logic [31:0] mem [0:255];
  logic [15:0] rd_log [0:255];
  logic [7:0]  got_b [0:255];
  logic        got_l [0:255];
  int rd_n = 0, wr_n = 0, got_n = 0;
  int mem_lat = 0, lat_cnt = 0, stall_mode = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Sink and memory model: decide inputs for the next edge, record what that edge accepts.
  always @(negedge clk) begin
    cyc++;
    tx_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (tx_valid && tx_ready && got_n < 256) begin
      got_b[got_n] = tx_data;
      got_l[got_n] = tx_last;
      got_n++;
    end
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat_cnt < mem_lat) lat_cnt++;
      else begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          wr_n++;
        end else begin
          mem_rdata = mem[mem_addr[9:2]];
          if (rd_n < 256) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
      end
    end else lat_cnt = 0;
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    rd_n = 0; wr_n = 0; got_n = 0;
  endtask

  task automatic set_base(logic [15:0] b);
    @(negedge clk); ring_base_we = 1'b1; ring_base_wdata = b;
    @(negedge clk); ring_base_we = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); xmit_go = 1'b1;
    @(negedge clk); xmit_go = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (xmit_busy && n < 4000) begin @(negedge clk); n++; end
    check(req, "engine stopped", xmit_busy, 0);
  endtask

  task automatic put_desc(int a, logic [31:0] w0, int len, int bufa);
    mem[a >> 2]       = w0;
    mem[(a >> 2) + 1] = {16'(len), 16'h0};
    mem[(a >> 2) + 2] = 32'(bufa);
  endtask

  task automatic fill(int a, int len, logic [7:0] seed);
    for (int j = 0; j < (len + 3) / 4; j++)
      for (int b = 0; b < 4; b++)
        mem[(a >> 2) + j][8*b +: 8] = seed + 8'(4*j + b);
  endtask

  task automatic chk_frame(string req, int at, int len, logic [7:0] seed);
    for (int k = 0; k < len; k++) begin
      check(req, "byte", got_b[at + k], seed + 8'(k));
      check(req, "last flag", got_l[at + k], (k == len - 1));
    end
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", xmit_busy, 0);
    check("R1", "mem_req after reset", mem_req, 0);
    check("R1", "tx_valid after reset", tx_valid, 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    stall_mode = 0; mem_lat = 0;
    set_base(16'h0100);
    put_desc(16'h100, OWN | WHOL, 6, 16'h200);
    fill(16'h200, 6, 8'h10);
    mem[16'h10C >> 2] = WHOL;
    clr_logs();
    pulse_go();
    check("R3", "busy while running", xmit_busy, 1);
    wait_idle("R3");
    check("R2", "first read", rd_log[0], 16'h100);
    check("R2", "second read", rd_log[1], 16'h104);
    check("R2", "third read", rd_log[2], 16'h108);
    check("R4", "byte count", got_n, 6);
    chk_frame("R4", 0, 6, 8'h10);
    check("R6", "written back word0", mem[16'h100 >> 2], WHOL);
    check("R3", "unowned desc untouched", mem[16'h10C >> 2], WHOL);
    check("R3", "write count", wr_n, 1);
    check("R7", "next desc read", rd_log[rd_n - 1], 16'h10C);
  endtask

  task automatic t_ring();
    stall_mode = 1; mem_lat = 2;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    set_base(16'h0100);
    put_desc(16'h100, OWN | WHOL, 7, 16'h200);
    fill(16'h200, 7, 8'h40);
    put_desc(16'h10C, OWN | WHOL, 0, 16'h280);
    put_desc(16'h118, OWN | LST | WHOL, 9, 16'h302);
    fill(16'h300, 9, 8'h80);
    put_desc(16'h124, OWN | WHOL, 3, 16'h380);
    clr_logs();
    pulse_go();
    wait_idle("R7");
    check("R8", "bytes under back-pressure", got_n, 16);
    chk_frame("R8", 0, 7, 8'h40);
    chk_frame("R5", 7, 9, 8'h80);
    check("R9", "zero-length written back", mem[16'h10C >> 2], WHOL);
    check("R6", "last flag kept", mem[16'h118 >> 2], LST | WHOL);
    check("R7", "wrapped to base", rd_log[rd_n - 1], 16'h100);
    check("R7", "beyond last untouched", mem[16'h124 >> 2], OWN | WHOL);
    // re-arm the first descriptor: the stopped pointer must sit at the base
    put_desc(16'h100, OWN | WHOL, 3, 16'h200);
    clr_logs();
    pulse_go();
    wait_idle("R7");
    check("R7", "restart at base", rd_log[0], 16'h100);
    check("R7", "restart bytes", got_n, 3);
    chk_frame("R7", 0, 3, 8'h40);
  endtask

  task automatic t_busy_and_reset();
    stall_mode = 1; mem_lat = 1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    set_base(16'h0100);
    put_desc(16'h100, OWN | LST | WHOL, 40, 16'h200);
    fill(16'h200, 40, 8'h20);
    clr_logs();
    pulse_go();
    repeat (10) @(negedge clk);
    xmit_go = 1'b1; ring_base_we = 1'b1; ring_base_wdata = 16'h0180;
    @(negedge clk);
    xmit_go = 1'b0; ring_base_we = 1'b0;
    wait_idle("R10");
    check("R10", "frame intact", got_n, 40);
    chk_frame("R10", 0, 40, 8'h20);
    check("R10", "base unchanged", rd_log[rd_n - 1], 16'h100);
    // soft reset in the middle of a frame
    put_desc(16'h100, OWN | LST | WHOL, 40, 16'h200);
    pulse_go();
    repeat (15) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R11", "busy after soft reset", xmit_busy, 0);
    check("R11", "tx_valid after soft reset", tx_valid, 0);
    check("R11", "no write-back", mem[16'h100 >> 2], OWN | LST | WHOL);
    @(negedge clk);
    clr_logs();
    pulse_go();
    wait_idle("R11");
    check("R11", "fetch from base", rd_log[0], 16'h100);
    check("R11", "full resend", got_n, 40);
    chk_frame("R11", 0, 40, 8'h20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_ring();
    t_busy_and_reset();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule